// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Interface

This block is the register front end that a host processor sees when it talks to a two-channel asynchronous serial controller. The host drives an 8-bit data bus, a chip select, a read/write strobe and a 4-bit register address. The block answers each access with a one-clock active-low transfer acknowledge. Read data is presented with an output enable. One side of the address map belongs to each channel. The rest holds shared registers: interrupt mask and status, the interrupt vector, counter presets, the output port and its configuration, and the input port. The serial shifters, baud generation and the counter datapath are outside this block. Where the host reaches them, they appear only as plain stub registers.

Several addresses lead to different registers depending on direction. The mode address of each channel is routed through a two-position sticky pointer. On first use it reaches mode register 1, and from then on it reaches mode register 2. The interrupt request is active low and follows the masked interrupt status. An interrupt-acknowledge cycle places the vector on the bus. That cycle is acknowledged only while a request is pending.

Top module: `dsc_host_regs`

## Requirements
- R1: After reset: `ack_n` and `irq_n` are high, `out_port` is 0xFF, `out_cfg` is 0x00 and `ct_run` is 0. The vector register reads 0x0F, the interrupt mask and status are clear, and both mode pointers select mode register 1.
- R2: A bus cycle starts at the first rising edge where `cs_n` is low after it was high. `ack_n` is low for exactly the one clock after that edge, even if `cs_n` stays low longer. `rdata_oe` is high in that clock only for reads (`rw`=1).
- R3: Channel A uses addresses 0x0–0x3 and channel B uses 0x8–0xB. At offset 0 is the mode register. At offset 1, a read returns status (0x00, since no serial datapath sets it) and a write goes to clock select, which cannot be read back. At offset 3, a write loads the transmit holding stub and a read returns the receive holding stub, which holds the last byte written to that channel's transmit holding stub.
- R4: Each access to a channel's mode address, read or write, reaches mode register 1 while the pointer is at position 1 and then moves the pointer to position 2. All later accesses reach mode register 2.
- R5: Writing the command register (channel offset 2) with bits [6:4] equal to 3'b001 returns that channel's pointer to mode register 1. The other channel's pointer is left as it was.
- R6: The interrupt status register samples the eight `int_src` lines on every clock. `irq_n` is low exactly when the status ANDed with the mask is nonzero. Address 0x5 reads the status and writes the mask.
- R7: An interrupt-acknowledge cycle (`iack_n` falling while `cs_n` is high) with a request pending drives the vector register onto `rdata`, with `rdata_oe` high and `ack_n` low for one clock. With nothing pending, `ack_n` and `rdata_oe` stay high and low respectively.
- R8: A read of 0xE sets `ct_run` and a read of 0xF clears it. A write to 0xE sets the output port register bits given by `wdata`, and a write to 0xF clears them. `out_port` is the inverse of the output port register.
- R9: 0xC reads and writes the vector register. 0xD reads {2'b00, `in_port`} and writes the output configuration register, which appears on `out_cfg`. 0x6 and 0x7 write and read back the upper and lower counter presets.
- R10: Reads of the reserved addresses 0x2 and 0xA, and of the input change address 0x4, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or interrupt vector |
| rdata_oe | output | 1 | Data bus output enable |
| ack_n | output | 1 | Transfer acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| int_src | input | 8 | Interrupt condition lines |
| in_port | input | 6 | General input port |
| out_port | output | 8 | General output port (inverted register) |
| out_cfg | output | 8 | Output configuration register |
| ct_run | output | 1 | Counter run flag |

## Verification
Register writes take effect at the first edge of a cycle. At that same edge `ack_n`, `rdata` and `rdata_oe` are registered. The bench drives each cycle on a falling edge and samples all three on the next falling edge, which is half a clock after they settle. The bench keeps `cs_n` low for two or more clocks in one test, to check that the acknowledge does not come back. `irq_n` follows `int_src` with one register in between, so after each change of the interrupt lines the bench waits one full clock before it samples. `out_port`, `out_cfg` and `ct_run` are checked after the idle clock that ends each access.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int IPW = 6;
  localparam int NCH = 2;

  // channel-local offsets (addr[1:0]) when addr[2] == 0
  localparam logic [1:0] OFS_MODE = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_HOLD = 2'd3;

  // shared addresses
  localparam logic [AW-1:0] A_CHG_AUX  = 4'h4;
  localparam logic [AW-1:0] A_IST_IMSK = 4'h5;
  localparam logic [AW-1:0] A_CT_HI    = 4'h6;
  localparam logic [AW-1:0] A_CT_LO    = 4'h7;
  localparam logic [AW-1:0] A_VEC      = 4'hC;
  localparam logic [AW-1:0] A_INP_CFG  = 4'hD;
  localparam logic [AW-1:0] A_GO_SET   = 4'hE;
  localparam logic [AW-1:0] A_HALT_CLR = 4'hF;

  localparam logic [2:0]    CMD_PTR_HOME = 3'b001;
  localparam logic [DW-1:0] VEC_RST      = 8'h0F;

  typedef struct packed {
    logic wr_mode;
    logic rd_mode;
    logic wr_cmd;
    logic wr_hold;
  } chan_strb_t;

  typedef struct packed {
    logic wr_imsk;
    logic wr_vec;
    logic wr_cfg;
    logic wr_set;
    logic wr_clr;
    logic wr_cthi;
    logic wr_ctlo;
    logic rd_go;
    logic rd_halt;
  } shr_strb_t;
endpackage

// File: rtl/dsc_bus_ctl.sv
module dsc_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rw,
  input  logic iack_n,
  input  logic irq_pend,
  output logic acc_go,
  output logic iack_go,
  output logic ack_n,
  output logic oe
);
  logic busy_q, busy_d;
  logic ack_q, ack_d;
  logic oe_q, oe_d;
  logic start;

  always_comb begin
    start   = ~busy_q & (~cs_n | ~iack_n);
    acc_go  = start & ~cs_n;
    iack_go = start & cs_n & ~iack_n & irq_pend;
    busy_d  = ~cs_n | ~iack_n;
    ack_d   = acc_go | iack_go;
    oe_d    = (acc_go & rw) | iack_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ack_q  <= ack_d;
      oe_q   <= oe_d;
    end
  end

  assign ack_n = ~ack_q;
  assign oe    = oe_q;

  // R2: acknowledge is a single clock per cycle
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);
  // R2: output enable only inside an acknowledged cycle
  p_oe_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ack_n);
endmodule

// File: rtl/dsc_chan_regs.sv
module dsc_chan_regs
  import dsc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  chan_strb_t    strb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_rd,
  output logic [DW-1:0] hold_rd,
  output logic          ptr_at2
);
  logic          ptr_q, ptr_d;
  logic [DW-1:0] mr1_q, mr1_d, mr2_q, mr2_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          ptr_home;

  always_comb begin
    ptr_home = strb.wr_cmd && (wdata[6:4] == CMD_PTR_HOME);
    ptr_d  = ptr_q;
    mr1_d  = mr1_q;
    mr2_d  = mr2_q;
    hold_d = hold_q;
    if (ptr_home)
      ptr_d = 1'b0;
    else if (strb.wr_mode || strb.rd_mode)
      ptr_d = 1'b1;
    if (strb.wr_mode && !ptr_q) mr1_d = wdata;
    if (strb.wr_mode &&  ptr_q) mr2_d = wdata;
    if (strb.wr_hold) hold_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      mr1_q  <= '0;
      mr2_q  <= '0;
      hold_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      mr1_q  <= mr1_d;
      mr2_q  <= mr2_d;
      hold_q <= hold_d;
    end
  end

  assign mode_rd = ptr_q ? mr2_q : mr1_q;
  assign hold_rd = hold_q;
  assign ptr_at2 = ptr_q;

  // R4: any mode access leaves the pointer at position 2
  p_ptr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wr_mode || strb.rd_mode) |=> ptr_at2);
  // R4: a write at position 2 leaves mode register 1 untouched
  p_mr1_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wr_mode && ptr_at2) |=> $stable(mr1_q));
  // R5: home command returns the pointer
  p_ptr_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wr_cmd && wdata[6:4] == CMD_PTR_HOME) |=> !ptr_at2);
endmodule

// File: rtl/dsc_shared_regs.sv
module dsc_shared_regs
  import dsc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  shr_strb_t     strb,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] int_src,
  output logic [DW-1:0] imsk_q,
  output logic [DW-1:0] ist_q,
  output logic [DW-1:0] vec_q,
  output logic [DW-1:0] opr_q,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] cthi_q,
  output logic [DW-1:0] ctlo_q,
  output logic          run_q
);
  logic [DW-1:0] imsk_d, vec_d, opr_d, cfg_d, cthi_d, ctlo_d;
  logic          run_d;

  always_comb begin
    imsk_d = imsk_q;
    vec_d  = vec_q;
    opr_d  = opr_q;
    cfg_d  = cfg_q;
    cthi_d = cthi_q;
    ctlo_d = ctlo_q;
    run_d  = run_q;
    if (strb.wr_imsk) imsk_d = wdata;
    if (strb.wr_vec)  vec_d  = wdata;
    if (strb.wr_cfg)  cfg_d  = wdata;
    if (strb.wr_cthi) cthi_d = wdata;
    if (strb.wr_ctlo) ctlo_d = wdata;
    if (strb.wr_set)  opr_d  = opr_q | wdata;
    if (strb.wr_clr)  opr_d  = opr_q & ~wdata;
    if (strb.rd_go)   run_d  = 1'b1;
    if (strb.rd_halt) run_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imsk_q <= '0;
      ist_q  <= '0;
      vec_q  <= VEC_RST;
      opr_q  <= '0;
      cfg_q  <= '0;
      cthi_q <= '0;
      ctlo_q <= '0;
      run_q  <= 1'b0;
    end else begin
      imsk_q <= imsk_d;
      ist_q  <= int_src;
      vec_q  <= vec_d;
      opr_q  <= opr_d;
      cfg_q  <= cfg_d;
      cthi_q <= cthi_d;
      ctlo_q <= ctlo_d;
      run_q  <= run_d;
    end
  end

  // R8: set and clear commands on the output port register
  p_set_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wr_set |=> ((opr_q & $past(wdata)) == $past(wdata)));
  p_clr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wr_clr |=> ((opr_q & $past(wdata)) == '0));
  // R8: counter start and stop reads
  p_ct_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd_go |=> run_q);
  p_ct_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd_halt |=> !run_q);
  // R6: status follows the condition lines by one clock
  p_ist_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ist_q == $past(int_src)));
endmodule

// File: rtl/dsc_host_regs.sv
module dsc_host_regs
  import dsc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rw,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           rdata_oe,
  output logic           ack_n,
  output logic           irq_n,
  input  logic           iack_n,
  input  logic [DW-1:0]  int_src,
  input  logic [IPW-1:0] in_port,
  output logic [DW-1:0]  out_port,
  output logic [DW-1:0]  out_cfg,
  output logic           ct_run
);
  localparam int SYNC = 2;

  logic [SYNC-1:0] rst_sync_q;
  logic            rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC-1];

  logic acc_go, iack_go, irq_pend;
  logic wr_go, rd_go_any, in_chan;

  logic [DW-1:0] imsk_q, ist_q, vec_q, opr_q, cfg_q, cthi_q, ctlo_q;
  logic          run_q;

  chan_strb_t    ch_strb [NCH];
  logic [DW-1:0] ch_mode [NCH];
  logic [DW-1:0] ch_hold [NCH];
  logic          ch_ptr  [NCH];
  shr_strb_t     sh_strb;

  logic [DW-1:0] rd_mux, rdata_q, rdata_d;

  assign irq_pend = |(ist_q & imsk_q);

  dsc_bus_ctl u_bus (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cs_n     (cs_n),
    .rw       (rw),
    .iack_n   (iack_n),
    .irq_pend (irq_pend),
    .acc_go   (acc_go),
    .iack_go  (iack_go),
    .ack_n    (ack_n),
    .oe       (rdata_oe)
  );

  always_comb begin
    wr_go     = acc_go & ~rw;
    rd_go_any = acc_go & rw;
    in_chan   = ~addr[2];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    always_comb begin
      hit = in_chan && (addr[3] == c[0]);
      ch_strb[c].wr_mode = wr_go     && hit && (addr[1:0] == OFS_MODE);
      ch_strb[c].rd_mode = rd_go_any && hit && (addr[1:0] == OFS_MODE);
      ch_strb[c].wr_cmd  = wr_go     && hit && (addr[1:0] == OFS_CMD);
      ch_strb[c].wr_hold = wr_go     && hit && (addr[1:0] == OFS_HOLD);
    end

    dsc_chan_regs u_chan (
      .clk     (clk),
      .rst_n   (rst_ni),
      .strb    (ch_strb[c]),
      .wdata   (wdata),
      .mode_rd (ch_mode[c]),
      .hold_rd (ch_hold[c]),
      .ptr_at2 (ch_ptr[c])
    );
  end

  always_comb begin
    sh_strb.wr_imsk = wr_go     && (addr == A_IST_IMSK);
    sh_strb.wr_vec  = wr_go     && (addr == A_VEC);
    sh_strb.wr_cfg  = wr_go     && (addr == A_INP_CFG);
    sh_strb.wr_set  = wr_go     && (addr == A_GO_SET);
    sh_strb.wr_clr  = wr_go     && (addr == A_HALT_CLR);
    sh_strb.wr_cthi = wr_go     && (addr == A_CT_HI);
    sh_strb.wr_ctlo = wr_go     && (addr == A_CT_LO);
    sh_strb.rd_go   = rd_go_any && (addr == A_GO_SET);
    sh_strb.rd_halt = rd_go_any && (addr == A_HALT_CLR);
  end

  dsc_shared_regs u_shr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .strb    (sh_strb),
    .wdata   (wdata),
    .int_src (int_src),
    .imsk_q  (imsk_q),
    .ist_q   (ist_q),
    .vec_q   (vec_q),
    .opr_q   (opr_q),
    .cfg_q   (cfg_q),
    .cthi_q  (cthi_q),
    .ctlo_q  (ctlo_q),
    .run_q   (run_q)
  );

  // read multiplexer: direction-split addresses resolve to the read side
  always_comb begin
    rd_mux = '0;
    if (in_chan) begin
      case (addr[1:0])
        OFS_MODE: rd_mux = ch_mode[addr[3]];
        OFS_HOLD: rd_mux = ch_hold[addr[3]];
        default:  rd_mux = '0;  // status stub and reserved diagnostic
      endcase
    end else begin
      case (addr)
        A_IST_IMSK: rd_mux = ist_q;
        A_CT_HI:    rd_mux = cthi_q;
        A_CT_LO:    rd_mux = ctlo_q;
        A_VEC:      rd_mux = vec_q;
        A_INP_CFG:  rd_mux = {{(DW-IPW){1'b0}}, in_port};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (iack_go)        rdata_d = vec_q;
    else if (rd_go_any) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign irq_n    = ~irq_pend;
  assign out_port = ~opr_q;
  assign out_cfg  = cfg_q;
  assign ct_run   = run_q;

  // R7: a vector cycle puts the vector on the bus with acknowledge
  p_iack_vec_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    iack_go |=> (!ack_n && rdata_oe && rdata == vec_q));
  // R7: no vector cycle without a pending request
  p_iack_pend_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    iack_go |-> !irq_n);
  // R2: a write cycle never enables the data bus
  p_wr_no_oe_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_go |=> !rdata_oe);
  // R5: the home command on one channel leaves the other pointer alone
  p_ptr_indep_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ch_strb[0].wr_cmd |=> (ch_ptr[1] == $past(ch_ptr[1])));
endmodule

// File: tb/dsc_host_regs_bench.sv
module dsc_host_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rw, iack_n;
  logic [3:0] addr;
  logic [7:0] wdata, int_src, rdata, out_port, out_cfg;
  logic [5:0] in_port;
  logic       rdata_oe, ack_n, irq_n, ct_run;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dsc_host_regs u_dsc_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
    .irq_n(irq_n), .iack_n(iack_n), .int_src(int_src), .in_port(in_port),
    .out_port(out_port), .out_cfg(out_cfg), .ct_run(ct_run)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  logic [7:0] s_rd;
  logic       s_ack, s_oe;

  task automatic bus_op(input logic r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = r; addr = a; wdata = d;
    @(negedge clk);
    s_rd = rdata; s_ack = ack_n; s_oe = rdata_oe;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  // {rw, addr, wdata, expected read, compare read}
  localparam int NV = 30;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 4'h0, 8'h13, 8'h00, 1'b0},  // R4 MR1A
    {1'b0, 4'h0, 8'h97, 8'h00, 1'b0},  // R4 MR2A
    {1'b1, 4'h0, 8'h00, 8'h97, 1'b1},  // R4 pointer sticky at 2
    {1'b0, 4'h2, 8'h10, 8'h00, 1'b0},  // R5 home channel A
    {1'b1, 4'h0, 8'h00, 8'h13, 1'b1},  // R5 back at MR1A
    {1'b1, 4'h0, 8'h00, 8'h97, 1'b1},  // R4 read moved pointer
    {1'b0, 4'h8, 8'h21, 8'h00, 1'b0},  // R3 MR1B
    {1'b1, 4'h8, 8'h00, 8'h00, 1'b1},  // R3 MR2B still reset
    {1'b0, 4'hA, 8'h20, 8'h00, 1'b0},  // R5 non-home command
    {1'b1, 4'h8, 8'h00, 8'h00, 1'b1},  // R5 pointer B stays at 2
    {1'b1, 4'h0, 8'h00, 8'h97, 1'b1},  // R5 pointer A unaffected
    {1'b0, 4'h3, 8'h5A, 8'h00, 1'b0},  // R3 hold A
    {1'b0, 4'hB, 8'hC3, 8'h00, 1'b0},  // R3 hold B
    {1'b1, 4'h3, 8'h00, 8'h5A, 1'b1},  // R3
    {1'b1, 4'hB, 8'h00, 8'hC3, 1'b1},  // R3
    {1'b0, 4'h1, 8'hFF, 8'h00, 1'b0},  // R3 clock select
    {1'b1, 4'h1, 8'h00, 8'h00, 1'b1},  // R3 status side
    {1'b1, 4'h9, 8'h00, 8'h00, 1'b1},  // R3 status B
    {1'b1, 4'h2, 8'h00, 8'h00, 1'b1},  // R10 reserved
    {1'b1, 4'hA, 8'h00, 8'h00, 1'b1},  // R10 reserved
    {1'b1, 4'h4, 8'h00, 8'h00, 1'b1},  // R10 change stub
    {1'b0, 4'hC, 8'h40, 8'h00, 1'b0},  // R9 vector
    {1'b1, 4'hC, 8'h00, 8'h40, 1'b1},  // R9
    {1'b0, 4'h6, 8'h12, 8'h00, 1'b0},  // R9 preset hi
    {1'b0, 4'h7, 8'h34, 8'h00, 1'b0},  // R9 preset lo
    {1'b1, 4'h6, 8'h00, 8'h12, 1'b1},  // R9
    {1'b1, 4'h7, 8'h00, 8'h34, 1'b1},  // R9
    {1'b0, 4'h5, 8'h81, 8'h00, 1'b0},  // R6 mask
    {1'b1, 4'hD, 8'h00, 8'h2B, 1'b1},  // R9 input port
    {1'b0, 4'hD, 8'h5A, 8'h00, 1'b0}   // R9 output config
  };

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; iack_n = 1'b1;
    addr = '0; wdata = '0; int_src = '0; in_port = 6'h2B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ack_n", {7'd0, ack_n}, 8'h01);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 out_port", out_port, 8'hFF);
    check("R1 out_cfg", out_cfg, 8'h00);
    check("R1 ct_run", {7'd0, ct_run}, 8'h00);
    bus_op(1'b1, 4'hC, 8'h00);
    check("R1 vector", s_rd, 8'h0F);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][21], VEC[i][20:17], VEC[i][16:9]);
      check("R2 ack", {7'd0, s_ack}, 8'h00);
      check("R2 oe", {7'd0, s_oe}, {7'd0, VEC[i][21]});
      if (VEC[i][0]) check("R3/R4/R5/R9/R10 data", s_rd, VEC[i][8:1]);
    end
    check("R9 out_cfg", out_cfg, 8'h5A);

    // R8 output port set / clear
    bus_op(1'b0, 4'hE, 8'h0F);
    check("R8 set", out_port, 8'hF0);
    bus_op(1'b0, 4'hF, 8'h05);
    check("R8 clear", out_port, 8'hF5);
    // R8 counter start / stop
    bus_op(1'b1, 4'hE, 8'h00);
    check("R8 start", {7'd0, ct_run}, 8'h01);
    bus_op(1'b1, 4'hF, 8'h00);
    check("R8 stop", {7'd0, ct_run}, 8'h00);

    // R2 held chip select gives one acknowledge only
    @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = 4'hC;
    @(negedge clk); check("R2 first ack", {7'd0, ack_n}, 8'h00);
    @(negedge clk); check("R2 held no ack", {7'd0, ack_n}, 8'h01);
    @(negedge clk); check("R2 held no ack", {7'd0, ack_n}, 8'h01);
    cs_n = 1'b1;
    @(negedge clk);

    // R6 masked interrupt (mask 0x81)
    int_src = 8'h02;
    @(negedge clk); @(negedge clk);
    check("R6 unmasked source", {7'd0, irq_n}, 8'h01);
    int_src = 8'h01;
    @(negedge clk); @(negedge clk);
    check("R6 masked source", {7'd0, irq_n}, 8'h00);
    int_src = 8'h82;
    bus_op(1'b1, 4'h5, 8'h00);
    check("R6 status read", s_rd, 8'h82);

    // R7 vector cycle with pending request
    @(negedge clk); iack_n = 1'b0;
    @(negedge clk);
    check("R7 ack", {7'd0, ack_n}, 8'h00);
    check("R7 oe", {7'd0, rdata_oe}, 8'h01);
    check("R7 vector", rdata, 8'h40);
    iack_n = 1'b1;
    int_src = 8'h00;
    @(negedge clk); @(negedge clk);
    check("R6 cleared", {7'd0, irq_n}, 8'h01);
    // R7 vector cycle without request
    iack_n = 1'b0;
    @(negedge clk);
    check("R7 no ack", {7'd0, ack_n}, 8'h01);
    check("R7 no oe", {7'd0, rdata_oe}, 8'h00);
    iack_n = 1'b1;
    @(negedge clk);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    int_src = 8'h01;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_port", out_port, 8'hFF);
    check("R1 out_cfg", out_cfg, 8'h00);
    check("R1 mask clear", {7'd0, irq_n}, 8'h01);
    bus_op(1'b1, 4'hC, 8'h00);
    check("R1 vector", s_rd, 8'h0F);
    bus_op(1'b0, 4'h0, 8'h66);
    bus_op(1'b0, 4'h2, 8'h10);
    bus_op(1'b1, 4'h0, 8'h00);
    check("R1 pointer at MR1", s_rd, 8'h66);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule